// File: doc/BRIEF.md
# Load Result Formatter

This block turns the raw bytes returned by a memory read into the value that is written to the destination register. The loaded bytes arrive right-aligned in a 64-bit word, with the most significant loaded byte nearest the top. Alongside each word come an access size of one, two, four or eight bytes and a formatting mode. The mode selects zero-fill, sign-fill or reversal of the byte order. A single datapath serves all three modes: a mask-and-fill stage handles both kinds of extension, and a set of per-size byte-swap networks handles reversal.

Some size and mode pairs match no real load operation. The block rejects these: it raises an error flag and returns zero, so the destination cannot receive a half-formatted value. By default the result is registered and appears one clock after the input. The `OUT_REG` parameter removes the register and leaves a purely combinational path. Address alignment, the memory access itself and exceptions belong to the surrounding load pipeline.

Top module: `ldfmt_unit`

## Requirements
- R1: With mode code 0 (zero-fill) and size code 0 (1 byte), the result carries input bits [7:0] in bits [7:0] and zeros in bits [63:8].
- R2: With mode code 0, size code 1 (2 bytes) keeps bits [15:0] and clears [63:16]; size code 2 (4 bytes) keeps bits [31:0] and clears [63:32].
- R3: With mode code 1 (sign-fill), size code 1 copies input bit 15 into bits [63:16] and size code 2 copies input bit 31 into bits [63:32]; the low bits pass unchanged.
- R4: With mode code 0 and size code 3 (8 bytes), the result equals the 64-bit input.
- R5: With mode code 2 (reverse) and size code 1, result byte [7:0] is input byte [15:8], result byte [15:8] is input byte [7:0], and bits [63:16] are zero.
- R6: With mode code 2 and size code 2, the four low input bytes appear in reverse order in bits [31:0] and bits [63:32] are zero. With size code 3, all eight bytes appear in reverse order.
- R7: The following pairs assert out_err and force out_result to zero: mode 1 with size code 0 or 3, mode 2 with size code 0, and mode code 3 with any size.
- R8: Every legal pair leaves out_err low. out_err is never high while out_valid is low.
- R9: With OUT_REG=1, out_valid, out_err and out_result reflect the input presented one clock earlier. Back-to-back inputs produce back-to-back outputs.
- R10: A cycle with in_valid low drives out_valid and out_err low and holds out_result at its last value. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_raw | input | 64 | Raw loaded bytes, right-aligned |
| in_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| in_mode | input | 2 | Mode code: 0 zero-fill, 1 sign-fill, 2 reverse, 3 reserved |
| out_valid | output | 1 | Result is present |
| out_result | output | 64 | Formatted register value |
| out_err | output | 1 | Rejected size/mode pair |

## Verification
Rejection of an illegal pair and delivery of a formatted value can happen on adjacent clocks. Because the output register updates every clock, the zero-forcing of one result and the valid data of its neighbour can land in the same register stage. The bench provokes this by alternating legal and illegal pairs on consecutive cycles, with idle gaps mixed in. It also sweeps all sixteen size/mode codes with random data. A behavioural model built on loops and integers predicts the valid flag, the error flag and the held or new result for every clock, and the bench compares all three on each cycle.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    typedef enum logic [1:0] {
        FMT_ZERO = 2'd0,
        FMT_SIGN = 2'd1,
        FMT_REV  = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_mode_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/ldfmt_legal.sv
module ldfmt_legal
    import ldfmt_pkg::*;
#(
    parameter int SZ_W   = 2,
    parameter int MAX_SZ = 3
) (
    input  logic [SZ_W-1:0] size_i,
    input  fmt_mode_e       mode_i,
    output logic            legal_o
);

    logic smallest;
    logic largest;

    always_comb begin
        smallest = (size_i == '0);
        largest  = (int'(size_i) == MAX_SZ);
        unique case (mode_i)
            FMT_ZERO: legal_o = 1'b1;
            FMT_SIGN: legal_o = !smallest && !largest;
            FMT_REV:  legal_o = !smallest;
            default:  legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend
    import ldfmt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SZ_W   = 2
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [SZ_W-1:0]   size_i,
    input  logic              fill_sign_i,
    output logic [DATA_W-1:0] ext_o
);

    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int NSIZES = $clog2(NBYTES) + 1;

    logic [DATA_W-1:0] keep_mask [NSIZES];
    logic              top_bit   [NSIZES];

    for (genvar s = 0; s < NSIZES; s++) begin : g_size
        localparam int WIDTH = BYTE_W * (1 << s);
        if (WIDTH >= DATA_W) begin : g_full
            assign keep_mask[s] = '1;
        end else begin : g_part
            assign keep_mask[s] = {{(DATA_W-WIDTH){1'b0}}, {WIDTH{1'b1}}};
        end
        assign top_bit[s] = raw_i[WIDTH-1];
    end

    logic [DATA_W-1:0] mask_sel;
    logic              fill_bit;

    always_comb begin
        mask_sel = keep_mask[size_i];
        fill_bit = fill_sign_i && top_bit[size_i];
        ext_o    = (raw_i & mask_sel) | ({DATA_W{fill_bit}} & ~mask_sel);
    end

endmodule

// File: rtl/ldfmt_byterev.sv
module ldfmt_byterev
    import ldfmt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SZ_W   = 2
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [SZ_W-1:0]   size_i,
    output logic [DATA_W-1:0] rev_o
);

    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int NSIZES = $clog2(NBYTES) + 1;

    logic [DATA_W-1:0] swapped [NSIZES];

    for (genvar s = 0; s < NSIZES; s++) begin : g_net
        localparam int LANES = 1 << s;
        always_comb begin
            swapped[s] = '0;
            for (int b = 0; b < LANES; b++) begin
                swapped[s][b*BYTE_W +: BYTE_W] = raw_i[(LANES-1-b)*BYTE_W +: BYTE_W];
            end
        end
    end

    assign rev_o = swapped[size_i];

endmodule

// File: rtl/ldfmt_unit.sv
module ldfmt_unit
    import ldfmt_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b1,
    parameter int SZ_W    = $clog2($clog2(DATA_W/8) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_raw,
    input  logic [SZ_W-1:0]   in_size,
    input  logic [1:0]        in_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_err
);

    localparam int MAX_SZ = $clog2(DATA_W / BYTE_W);

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] res;
    } fmt_state_t;

    fmt_mode_e         mode;
    logic              legal;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] rev_val;
    fmt_state_t        st_d;
    fmt_state_t        st_q;

    assign mode = fmt_mode_e'(in_mode);

    ldfmt_legal #(.SZ_W(SZ_W), .MAX_SZ(MAX_SZ)) u_legal (
        .size_i  (in_size),
        .mode_i  (mode),
        .legal_o (legal)
    );

    ldfmt_extend #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_extend (
        .raw_i       (in_raw),
        .size_i      (in_size),
        .fill_sign_i (mode == FMT_SIGN),
        .ext_o       (ext_val)
    );

    ldfmt_byterev #(.DATA_W(DATA_W), .SZ_W(SZ_W)) u_rev (
        .raw_i  (in_raw),
        .size_i (in_size),
        .rev_o  (rev_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.err = 1'b0;
        if (in_valid) begin
            if (!legal) begin
                st_d.err = 1'b1;
                st_d.res = '0;
            end else if (mode == FMT_REV) begin
                st_d.res = rev_val;
            end else begin
                st_d.res = ext_val;
            end
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end
        assign out_valid  = st_q.vld;
        assign out_err    = st_q.err;
        assign out_result = st_q.res;
    end else begin : g_comb
        assign st_q       = '0;
        assign out_valid  = st_d.vld;
        assign out_err    = st_d.err;
        assign out_result = st_d.res;
    end

endmodule

// File: rtl/ldfmt_unit_chk.sv
module ldfmt_unit_chk #(
    parameter int DATA_W  = 64,
    parameter bit OUT_REG = 1'b1,
    parameter int SZ_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_raw,
    input logic [SZ_W-1:0]   in_size,
    input logic [1:0]        in_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_err
);

    AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_result == '0)); // R7

    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid); // R8

    if (OUT_REG) begin : g_seq
        AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid))); // R9

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_result) && !out_err)); // R10

        AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && $past(in_mode) == 2'd1 && $past(in_size) == 2'd1)
            |-> (out_result[DATA_W-1:15] == '0 || out_result[DATA_W-1:15] == '1)); // R3

        AST_DWORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && $past(in_mode) == 2'd0 && $past(in_size) == 2'd3)
            |-> (out_result == $past(in_raw) && !out_err)); // R4

        AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && $past(in_mode) == 2'd3) |-> out_err); // R7
    end

endmodule

bind ldfmt_unit ldfmt_unit_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG), .SZ_W(SZ_W)) u_chk (.*);

// File: tb/sim_ldfmt_unit.sv
module sim_ldfmt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_raw = '0;
    logic [1:0]  in_size = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_err;

    int checks = 0;
    int fails  = 0;

    logic        exp_v = 1'b0;
    logic        exp_e = 1'b0;
    logic [63:0] exp_r = '0;
    string       exp_tag = "R10";
    bit          pending = 1'b0;

    always #4 clk = ~clk;

    ldfmt_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_raw     (in_raw),
        .in_size    (in_size),
        .in_mode    (in_mode),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_err    (out_err)
    );

    function automatic bit is_legal(input int sz, input int md);
        if (md == 0) return 1'b1;
        if (md == 1) return (sz == 1 || sz == 2);
        if (md == 2) return (sz != 0);
        return 1'b0;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] raw, input int sz, input int md);
        logic [63:0] r;
        int nb;
        r  = '0;
        nb = 1 << sz;
        if (!is_legal(sz, md)) return '0;
        if (md == 2) begin
            for (int b = 0; b < nb; b++)
                for (int k = 0; k < 8; k++)
                    r[8*b + k] = raw[8*(nb-1-b) + k];
        end else begin
            for (int i = 0; i < 64; i++) begin
                if (i < 8*nb) r[i] = raw[i];
                else          r[i] = (md == 1) ? raw[8*nb-1] : 1'b0;
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input int sz, input int md);
        if (!is_legal(sz, md)) return "R7";
        if (md == 1) return "R3";
        if (md == 2) return (sz == 1) ? "R5" : "R6";
        if (sz == 0) return "R1";
        if (sz == 3) return "R4";
        return "R2";
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== exp_v || out_err !== exp_e || out_result !== exp_r) begin
            fails++;
            $display("FAIL %s (R8/R9 timing) actual v=%0b e=%0b r=%h expected v=%0b e=%0b r=%h",
                     exp_tag, out_valid, out_err, out_result, exp_v, exp_e, exp_r);
        end
    endtask

    // drive at a falling edge; the result is compared at the next falling edge
    task automatic step(input bit v, input logic [63:0] raw, input int sz, input int md);
        @(negedge clk);
        if (pending) compare();
        in_valid = v;
        in_raw   = raw;
        in_size  = sz[1:0];
        in_mode  = md[1:0];
        exp_v    = v;
        exp_e    = v && !is_legal(sz, md);
        if (v) begin
            exp_r   = model(raw, sz, md);
            exp_tag = tag_of(sz, md);
        end else begin
            exp_tag = "R10";
        end
        pending = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_result !== '0) begin
            fails++;
            $display("FAIL R10 reset actual v=%0b e=%0b r=%h expected 0 0 0",
                     out_valid, out_err, out_result);
        end
        rst_n = 1'b1;

        // directed corners
        step(1, 64'h0000_0000_0000_80FF, 0, 0);                  // R1
        step(1, 64'hFFFF_FFFF_FFFF_8001, 1, 0);                  // R2
        step(1, 64'hAAAA_AAAA_8000_0001, 2, 0);                  // R2
        step(1, 64'h1234_5678_0000_8001, 1, 1);                  // R3 negative
        step(1, 64'hFFFF_FFFF_FFFF_7FFF, 1, 1);                  // R3 positive
        step(1, 64'h0000_0000_8000_0000, 2, 1);                  // R3 word
        step(1, 64'hDEAD_BEEF_0BAD_F00D, 3, 0);                  // R4
        step(1, 64'hFFFF_FFFF_FFFF_A1B2, 1, 2);                  // R5
        step(1, 64'h0102_0304_0506_0708, 2, 2);                  // R6
        step(1, 64'h0102_0304_0506_0708, 3, 2);                  // R6
        step(0, 64'h5555_5555_5555_5555, 0, 0);                  // R10 hold
        step(0, 64'h0, 3, 3);                                    // R10 hold
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);                  // R7
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 3, 1);                  // R7
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 2);                  // R7
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2, 3);                  // R7

        // alternating legal / illegal back to back (R7, R8, R9)
        for (int i = 0; i < 64; i++) begin
            step(1, {$urandom, $urandom}, (i % 3) + 1, (i % 2) ? 0 : 3);
        end

        // full sweep with random data and random idle gaps
        for (int rep = 0; rep < 200; rep++) begin
            for (int md = 0; md < 4; md++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    step(($urandom % 5) != 0, {$urandom, $urandom}, sz, md);
                end
            end
        end

        step(0, 64'h0, 0, 0);
        @(negedge clk);
        compare();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule